// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Turnaround Idle Insertion

This block runs bus cycles on an external memory bus for an internal master. Each request names the target area, read or write, an address and write data. A per-area configuration bit selects a 3-state or a 2-state access for that area. The block drives the address, a read strobe, a write strobe and a data-drive enable. It returns read data together with a one-clock completion pulse. Each bus state lasts two clocks: a first half (phase 0) and a second half (phase 1).

Devices with a long output turn-off time can still be driving the data bus when the next device starts. To prevent this, the block remembers the type and area of the last bus cycle. It can then put one idle state in front of the next cycle. Two rules decide this, and each has its own enable bit. The first rule covers a read followed by a read to another area. The second covers a write that follows a read. The idle state always sits at the front of the second cycle. Both enable bits are set out of reset and can be reloaded through a small configuration strobe.

The controller states are `ST_IDLE`, `ST_GAP`, `ST_T1`, `ST_T2` and `ST_T3`. The transitions are as follows:
- `ST_IDLE` moves to `ST_GAP` or `ST_T1` on an accepted request.
- `ST_GAP` moves to `ST_T1` after one state.
- `ST_T1` moves to `ST_T2`.
- `ST_T2` moves to `ST_T3` for a 3-state area. Otherwise it ends the cycle.
- `ST_T3` ends the cycle.

When a cycle ends, the controller moves to `ST_GAP` or `ST_T1` if a request is taken in the same clock. Otherwise it moves to `ST_IDLE`.

Top module: `xbus_gap_seq`

## Requirements
- R1: After reset, `bus_rd`, `bus_wr`, `bus_oe` and `rsp_done` are 0 and `req_ready` is 1.
- R2: A cycle to an area whose `area_slow` bit is 1 takes 3 states (6 clocks). Otherwise it takes 2 states (4 clocks). Every state, including the idle state, lasts 2 clocks.
- R3: `bus_addr` changes only on entry to the first half of T1. It holds through the rest of the cycle and through any idle state that follows.
- R4: In a read cycle, `bus_rd` is 1 from the second half of T1 to the end of the last state, and 0 elsewhere. `bus_rd` and `bus_wr` are never both 1.
- R5: In a write cycle, `bus_oe` is 1 and `bus_wdata` carries the write data for the whole cycle. `bus_wr` is 1 from the second half of T1 through the first half of the last state.
- R6: `rsp_done` pulses for one clock in the clock after the last state ends. For a read, `rsp_rdata` then holds the `bus_rdata` value sampled at the end of the last state.
- R7: With the read-to-read enable at 1, a read to a different area that directly follows a read gets one idle state (2 clocks, no strobes, no drive) before its T1.
- R8: With the read-to-read enable at 0, back-to-back reads to different areas run with no gap.
- R9: With the write-after-read enable at 1, a write directly after a read gets one idle state, whatever the areas. With that enable at 0 there is no gap.
- R10: Reads to the same area, read after write, and write after write never get an idle state.
- R11: The remembered previous cycle is forgotten after one full state in `ST_IDLE` with `req_valid` low. A later request then starts at T1 with no idle state.
- R12: `req_ready` is 1 only in `ST_IDLE` or in the second half of a cycle's last state. A request taken at the end of a cycle starts its idle state or T1 in the next clock.
- R13: Both enable bits reset to 1. A clock with `cfg_we` at 1 loads them from `cfg_rr_en` (read-to-read rule) and `cfg_wr_en` (write-after-read rule).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load both idle-rule enables |
| cfg_rr_en | input | 1 | New read-to-read rule enable |
| cfg_wr_en | input | 1 | New write-after-read rule enable |
| area_slow | input | N_AREAS | Per-area select, 1 = 3-state access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | AREA_W | Target area number |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Write-data drive enable |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_rdata | input | DATA_W | Read data from the bus |

## Verification
On every cycle, the checker enforces the following:
- the read and write strobes never overlap;
- the idle state is quiet;
- the address moves only on entry to T1;
- a write strobe always comes with data drive;
- completion is a single-clock pulse;
- ready appears only in its permitted slot.

Whether an idle state should appear at all depends on the enables, the order of read and write, and the areas involved. Only the bench's scenarios can show that. They trace every strobe half-state by half-state for each pairing and enable setting. The bench scenarios also cover the reset value of the enables, the clearing of history after an idle stretch, and read-data capture.

// File: rtl/xbus_gap_pkg.sv
package xbus_gap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_T1,
        ST_T2,
        ST_T3
    } bus_st_e;

endpackage

// File: rtl/xbus_gap_hist.sv
// Remembers the kind and area of the most recently started bus cycle.
module xbus_gap_hist #(
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec,
    input  logic              rec_wr,
    input  logic [AREA_W-1:0] rec_area,
    input  logic              forget,
    output logic              h_valid,
    output logic              h_wr,
    output logic [AREA_W-1:0] h_area
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_valid <= 1'b0;
            h_wr    <= 1'b0;
            h_area  <= '0;
        end else if (rec) begin
            h_valid <= 1'b1;
            h_wr    <= rec_wr;
            h_area  <= rec_area;
        end else if (forget) begin
            h_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/xbus_gap_rules.sv
// Holds the two rule enables and decides whether a new cycle needs an idle state.
module xbus_gap_rules #(
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_rr_en,
    input  logic              cfg_wr_en,
    input  logic              h_valid,
    input  logic              h_wr,
    input  logic [AREA_W-1:0] h_area,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    output logic              need_gap
);

    logic rr_en_q;
    logic wr_en_q;
    logic after_read;
    logic hit_rr;
    logic hit_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_en_q <= 1'b1;
            wr_en_q <= 1'b1;
        end else if (cfg_we) begin
            rr_en_q <= cfg_rr_en;
            wr_en_q <= cfg_wr_en;
        end
    end

    always_comb begin
        after_read = h_valid && !h_wr;
        hit_rr     = rr_en_q && after_read && !req_write && (req_area != h_area);
        hit_wr     = wr_en_q && after_read && req_write;
        need_gap   = hit_rr || hit_wr;
    end

endmodule

// File: rtl/xbus_gap_fsm.sv
// Bus state sequencer: two clocks per bus state, strobes decoded from state and phase.
module xbus_gap_fsm
    import xbus_gap_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int AREA_W  = 3,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [N_AREAS-1:0] area_slow,
    input  logic              need_gap,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              req_ready,
    output logic              accept,
    output logic              forget,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_oe,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output bus_st_e           st,
    output logic              ph
);

    bus_st_e           st_q, st_d;
    logic              ph_q, ph_d;
    logic              cur_wr_q;
    logic              cur_slow_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [DATA_W-1:0] cur_wdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              last_st;
    logic              cyc_end;
    bus_st_e           start_st;

    assign last_st   = (st_q == ST_T3) || (st_q == ST_T2 && !cur_slow_q);
    assign cyc_end   = last_st && ph_q;
    assign req_ready = (st_q == ST_IDLE) || cyc_end;
    assign accept    = req_valid && req_ready;
    assign forget    = (st_q == ST_IDLE) && ph_q && !req_valid;
    assign start_st  = need_gap ? ST_GAP : ST_T1;

    // next state
    always_comb begin
        st_d = st_q;
        ph_d = ~ph_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_d = start_st;
                    ph_d = 1'b0;
                end
            end
            ST_GAP:  if (ph_q) st_d = ST_T1;
            ST_T1:   if (ph_q) st_d = ST_T2;
            ST_T2:   if (ph_q) st_d = cur_slow_q ? ST_T3 : (accept ? start_st : ST_IDLE);
            ST_T3:   if (ph_q) st_d = accept ? start_st : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            ph_q        <= 1'b0;
            cur_wr_q    <= 1'b0;
            cur_slow_q  <= 1'b0;
            cur_addr_q  <= '0;
            cur_wdata_q <= '0;
            addr_q      <= '0;
            rdata_q     <= '0;
            done_q      <= 1'b0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            done_q <= cyc_end;
            if (accept) begin
                cur_wr_q    <= req_write;
                cur_slow_q  <= area_slow[req_area];
                cur_addr_q  <= req_addr;
                cur_wdata_q <= req_wdata;
            end
            if (st_d == ST_T1 && st_q != ST_T1) begin
                addr_q <= accept ? req_addr : cur_addr_q;
            end
            if (cyc_end && !cur_wr_q) begin
                rdata_q <= bus_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        bus_oe = 1'b0;
        unique case (st_q)
            ST_T1: begin
                bus_rd = !cur_wr_q && ph_q;
                bus_wr = cur_wr_q && ph_q;
                bus_oe = cur_wr_q;
            end
            ST_T2: begin
                bus_rd = !cur_wr_q;
                bus_wr = cur_wr_q && (cur_slow_q || !ph_q);
                bus_oe = cur_wr_q;
            end
            ST_T3: begin
                bus_rd = !cur_wr_q;
                bus_wr = cur_wr_q && !ph_q;
                bus_oe = cur_wr_q;
            end
            ST_IDLE, ST_GAP: begin
                bus_rd = 1'b0;
            end
            default: bus_rd = 1'b0;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = cur_wdata_q;
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;
    assign st        = st_q;
    assign ph        = ph_q;

endmodule

// File: rtl/xbus_gap_seq.sv
module xbus_gap_seq
    import xbus_gap_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    localparam int AREA_W = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_rr_en,
    input  logic               cfg_wr_en,
    input  logic [N_AREAS-1:0] area_slow,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [AREA_W-1:0]  req_area,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic               bus_oe,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata
);

    logic              accept;
    logic              forget;
    logic              need_gap;
    logic              h_valid;
    logic              h_wr;
    logic [AREA_W-1:0] h_area;
    bus_st_e           fsm_st;
    logic              fsm_ph;

    xbus_gap_hist #(.AREA_W(AREA_W)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec      (accept),
        .rec_wr   (req_write),
        .rec_area (req_area),
        .forget   (forget),
        .h_valid  (h_valid),
        .h_wr     (h_wr),
        .h_area   (h_area)
    );

    xbus_gap_rules #(.AREA_W(AREA_W)) rules_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_rr_en (cfg_rr_en),
        .cfg_wr_en (cfg_wr_en),
        .h_valid   (h_valid),
        .h_wr      (h_wr),
        .h_area    (h_area),
        .req_write (req_write),
        .req_area  (req_area),
        .need_gap  (need_gap)
    );

    xbus_gap_fsm #(
        .N_AREAS (N_AREAS),
        .AREA_W  (AREA_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_area  (req_area),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .area_slow (area_slow),
        .need_gap  (need_gap),
        .bus_rdata (bus_rdata),
        .req_ready (req_ready),
        .accept    (accept),
        .forget    (forget),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_oe    (bus_oe),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .st        (fsm_st),
        .ph        (fsm_ph)
    );

endmodule

// File: rtl/xbus_gap_chk.sv
module xbus_gap_chk
    import xbus_gap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input bus_st_e           st,
    input logic              ph,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rsp_done,
    input logic              req_ready
);

    a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> (!bus_rd && !bus_wr && !bus_oe));

    a_r3_addr_at_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != $past(bus_addr)) |-> (st == ST_T1 && !ph));

    a_r5_strobe_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_oe);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r12_ready_slot: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (st == ST_IDLE || ph));

endmodule

bind xbus_gap_seq xbus_gap_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (fsm_st),
    .ph        (fsm_ph),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_oe    (bus_oe),
    .bus_addr  (bus_addr),
    .rsp_done  (rsp_done),
    .req_ready (req_ready)
);

// File: tb/xbus_gap_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_gap_seq_tb_top;

    localparam int N_AREAS = 8;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int AREA_W  = 3;
    localparam logic [15:0] RD_KEY = 16'h3C5A;
    localparam logic [7:0]  SLOW   = 8'h0F;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic               cfg_rr_en = 1'b0;
    logic               cfg_wr_en = 1'b0;
    logic [N_AREAS-1:0] area_slow = SLOW;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_write = 1'b0;
    logic [AREA_W-1:0]  req_area = '0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               rsp_done;
    logic [DATA_W-1:0]  rsp_rdata;
    logic [ADDR_W-1:0]  bus_addr;
    logic               bus_rd;
    logic               bus_wr;
    logic               bus_oe;
    logic [DATA_W-1:0]  bus_wdata;
    logic [DATA_W-1:0]  bus_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    assign bus_rdata = bus_addr ^ RD_KEY;

    xbus_gap_seq #(.N_AREAS(N_AREAS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rr_en(cfg_rr_en),
        .cfg_wr_en(cfg_wr_en), .area_slow(area_slow), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_area(req_area),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_oe(bus_oe), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input logic rr, input logic wr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rr_en = rr; cfg_wr_en = wr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_bus(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R1: reset values at the ports
    task automatic t_reset;
        check("R1", "bus_rd", bus_rd, 0);
        check("R1", "bus_wr", bus_wr, 0);
        check("R1", "bus_oe", bus_oe, 0);
        check("R1", "rsp_done", rsp_done, 0);
        check("R1", "req_ready", req_ready, 1);
    endtask

    // Two back-to-back requests, whole strobe trace checked per half-state.
    task automatic run_pair(input logic w0, input logic [2:0] a0,
                            input logic w1, input logic [2:0] a1,
                            input logic rr, input logic wr,
                            input logic [15:0] tagv, input string extra);
        logic [15:0] ad0, ad1, wd0, wd1;
        int n0, n1, g, total;
        string rt;
        logic drop;
        ad0 = 16'h1000 + tagv; ad1 = 16'h2000 + tagv;
        wd0 = 16'hA000 + tagv; wd1 = 16'hB000 + tagv;
        n0 = SLOW[a0] ? 3 : 2;
        n1 = SLOW[a1] ? 3 : 2;
        g = ((!w0 && !w1 && a0 != a1 && rr) || (!w0 && w1 && wr)) ? 1 : 0;
        if (g == 1)                       rt = w1 ? "R9" : "R7";
        else if (!w0 && !w1 && a0 != a1) rt = "R8";
        else if (!w0 && w1)              rt = "R9";
        else                             rt = "R10";
        rt = {rt, extra};
        total = 2*n0 + 2*g + 2*n1 + 1;
        idle_bus(4);
        req_valid = 1'b1; req_write = w0; req_area = a0; req_addr = ad0; req_wdata = wd0;
        check("R12", "ready_idle", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_write = w1; req_area = a1; req_addr = ad1; req_wdata = wd1;
        drop = 1'b0;
        for (int k = 0; k < total; k++) begin
            logic er, ew, eo, ed, cw;
            logic [15:0] ea, ewd;
            int j, nn;
            if (k > 0) @(negedge clk);
            if (drop) begin req_valid = 1'b0; drop = 1'b0; end
            er = 0; ew = 0; eo = 0; cw = 0; ewd = 0; j = 0; nn = 0;
            ea = ad1;
            if (k < 2*n0) begin
                j = k; nn = n0; cw = w0; ea = ad0; ewd = wd0;
            end else if (k < 2*n0 + 2*g) begin
                ea = ad0;
            end else if (k < total - 1) begin
                j = k - 2*n0 - 2*g; nn = n1; cw = w1; ewd = wd1;
            end
            if (nn != 0) begin
                er = !cw && (j >= 1);
                ew = cw && (j >= 1) && (j <= 2*nn - 2);
                eo = cw;
            end
            ed = (k == 2*n0) || (k == total - 1);
            check({"R4/", rt}, "bus_rd", bus_rd, er);
            check({"R5/", rt}, "bus_wr", bus_wr, ew);
            check({"R5/", rt}, "bus_oe", bus_oe, eo);
            check({"R3/", rt}, "bus_addr", bus_addr, ea);
            check({"R6/R2/", rt}, "rsp_done", rsp_done, ed);
            if (eo) check("R5", "bus_wdata", bus_wdata, ewd);
            if (k == 2*n0 && !w0) check("R6", "rsp_rdata0", rsp_rdata, ad0 ^ RD_KEY);
            if (k == total - 1 && !w1) check("R6", "rsp_rdata1", rsp_rdata, ad1 ^ RD_KEY);
            if (k == 0) check("R12", "ready_t1", req_ready, 0);
            if (k == 2*n0 - 1) check("R12", "ready_last", req_ready, 1);
            if (req_valid && req_ready) drop = 1'b1;
        end
        req_valid = 1'b0;
    endtask

    // R11: history forgotten after a full idle state
    task automatic t_forget;
        idle_bus(4);
        req_valid = 1'b1; req_write = 1'b0; req_area = 3'd2; req_addr = 16'h4444;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_area = 3'd5; req_addr = 16'h5555;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11", "addr_at_t1", bus_addr, 16'h5555);
        @(negedge clk);
        check("R11", "rd_no_gap", bus_rd, 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R13: enables come out of reset at 1, no configuration write yet
        run_pair(1'b0, 3'd2, 1'b0, 3'd5, 1'b1, 1'b1, 16'h0F0, "/R13");
        run_pair(1'b0, 3'd5, 1'b1, 3'd5, 1'b1, 1'b1, 16'h0F1, "/R13");
        for (int rr = 0; rr < 2; rr++)
            for (int wr = 0; wr < 2; wr++) begin
                set_cfg(rr[0], wr[0]);
                for (int a = 0; a < 2; a++)
                    for (int d = 0; d < 2; d++)
                        for (int w0 = 0; w0 < 2; w0++)
                            for (int w1 = 0; w1 < 2; w1++) begin
                                logic [2:0] a0, a1;
                                a0 = (a == 0) ? 3'd2 : 3'd5;
                                a1 = (d == 0) ? a0 : ~a0;
                                run_pair(w0[0], a0, w1[0], a1, rr[0], wr[0],
                                         16'(rr*32 + wr*16 + a*8 + d*4 + w0*2 + w1), "");
                            end
            end
        set_cfg(1'b1, 1'b1);
        t_forget();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule